// File: doc/BRIEF.md
# Nixie Cathode Exercise Sweeper

This block sits between a time-of-day counter and the tube drivers of a six-tube nixie clock. Most of the time it passes the live BCD time straight through to the display. On a schedule it takes over the display for a short interval. During that interval every tube shows the same numeral, and the numeral steps 0, 1, 2 … 9. The walk is repeated a set number of times, so that cathodes which are rarely lit still glow often enough to stay clean. When the walk finishes, the display goes back to whatever the live counter holds at that moment.

The block never drives the time counter, so time keeps running during the override. A schedule bit picks the trigger. With the bit clear, the sweep starts on every hour boundary. With the bit set, it starts only at 03:00. An enable input gates the feature: dropping it ends an override in the same cycle.

The step length in clock cycles and the number of 0–9 passes are parameters. For example, 20 ms per numeral and five passes gives about one second of override.

Top module: `cathode_exerciser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0 and `shown_bcd` equals `live_bcd`.
- R2: Whenever `busy` is 0, `shown_bcd` equals `live_bcd` in the same cycle.
- R3: The digit layout is as follows: nibble 0 holds seconds units, nibble 1 seconds tens, nibble 2 minutes units, nibble 3 minutes tens, nibble 4 hours units and nibble 5 hours tens. With `daily_sel`=0 and `enable`=1, a clock edge that samples `tick`=1 while minutes and seconds read 00:00 starts a sweep. `busy` is 1 from that edge on.
- R4: With `daily_sel`=1, a sweep starts only if, in addition, the hours read 03 (hours tens 0, hours units 3). Any other hour does not start a sweep.
- R5: No sweep starts without `tick`, with minutes or seconds not zero, or with `enable`=0.
- R6: During a sweep all six nibbles show the same numeral. The numeral is 0 for the first STEP_CYCLES cycles after the start edge, then rises by one every STEP_CYCLES cycles up to 9, and then wraps to 0.
- R7: A sweep runs PASSES complete 0–9 passes. `busy` stays high for exactly 10·STEP_CYCLES·PASSES cycles.
- R8: When a sweep ends, `shown_bcd` equals the live time at that moment, including any change made to `live_bcd` during the sweep.
- R9: `enable`=0 forces `busy` to 0 and `shown_bcd` to `live_bcd` in the same cycle. Raising `enable` again does not resume the aborted sweep.
- R10: A qualifying tick that arrives during a sweep neither restarts it nor lengthens it.
- R11: While `busy` is 1, every displayed nibble is a valid decimal numeral (at most 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| live_bcd | input | 24 | Live time, six BCD nibbles, seconds units in bits 3:0 |
| tick | input | 1 | One-cycle strobe marking a new second |
| daily_sel | input | 1 | 0: sweep every hour, 1: sweep only at 03:00 |
| enable | input | 1 | Feature enable; low aborts a running sweep |
| shown_bcd | output | 24 | BCD digits for the tube drivers |
| busy | output | 1 | High while the display is overridden |

## Verification
The start edge is the first clock edge that samples a qualifying tick. `busy` and numeral 0 appear directly after that edge. The numeral k is due from edge k·STEP_CYCLES, and `busy` falls at edge 10·STEP_CYCLES·PASSES. The bench drives the tick for exactly one cycle from a falling edge and counts falling edges from there, so each check lands half a cycle after the register update it depends on. Pass-through and abort are combinational, so those checks are made one time unit after the input changes, within the same cycle.

// File: rtl/cycler_pkg.sv
// Shared constants for the cathode exerciser: tube count, BCD nibble
// positions of the time fields and the hour that the daily schedule uses.
package cycler_pkg;
    localparam int TUBES      = 6;
    localparam int NIB        = 4;
    localparam int BCD_W      = TUBES * NIB;
    localparam int SEC_U      = 0;
    localparam int SEC_T      = 1;
    localparam int MIN_U      = 2;
    localparam int MIN_T      = 3;
    localparam int HR_U       = 4;
    localparam int HR_T       = 5;
    localparam logic [NIB-1:0] DAILY_HR_T = 4'd0;
    localparam logic [NIB-1:0] DAILY_HR_U = 4'd3;
    localparam logic [NIB-1:0] TOP_NUMERAL = 4'd9;

    // Extract nibble idx of a packed BCD time word.
    function automatic logic [NIB-1:0] nib(input logic [BCD_W-1:0] v, input int idx);
        return v[idx*NIB +: NIB];
    endfunction
endpackage

// File: rtl/sweep_trigger.sv
// Decides when an override begins. Purely combinational.
// Assumes live_bcd is valid BCD and tick is a single-cycle strobe.
module sweep_trigger
    import cycler_pkg::*;
(
    input  logic [BCD_W-1:0] live_bcd,
    input  logic             tick,
    input  logic             enable,
    input  logic             daily_sel,
    input  logic             idle,
    output logic             start
);
    logic on_hour;
    logic hour_ok;

    // Minutes and seconds both read zero, and the hour matches when daily.
    always_comb begin
        on_hour = (nib(live_bcd, SEC_U) == '0) && (nib(live_bcd, SEC_T) == '0) &&
                  (nib(live_bcd, MIN_U) == '0) && (nib(live_bcd, MIN_T) == '0);
        hour_ok = !daily_sel ||
                  ((nib(live_bcd, HR_T) == DAILY_HR_T) && (nib(live_bcd, HR_U) == DAILY_HR_U));
        start   = tick && enable && idle && on_hour && hour_ok;
    end
endmodule

// File: rtl/step_timer.sv
// Produces one step strobe every STEP_CYCLES cycles while run is high.
// restart or a low run clears the count, so the first step of a sweep
// comes exactly STEP_CYCLES cycles after run rises.
module step_timer #(
    parameter int STEP_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic step
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Count cycles within the current numeral.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe on the last cycle of a numeral.
    always_comb step = run && (cnt == LAST);
endmodule

// File: rtl/sweep_sequencer.sv
// Holds the override state: the active flag, the numeral on show and the
// pass counter. It advances the numeral on each step and ends after
// PASSES full walks. An abort clears the state at once. A start is only
// taken while idle.
module sweep_sequencer
    import cycler_pkg::*;
#(
    parameter int PASSES = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           step,
    input  logic           abort,
    output logic           active,
    output logic [NIB-1:0] numeral
);
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    logic [PASS_W-1:0] pass_q;

    // Sweep state register: start, step through numerals, count passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            numeral <= '0;
            pass_q  <= '0;
        end else if (abort) begin
            active  <= 1'b0;
            numeral <= '0;
            pass_q  <= '0;
        end else if (start && !active) begin
            active  <= 1'b1;
            numeral <= '0;
            pass_q  <= '0;
        end else if (active && step) begin
            if (numeral == TOP_NUMERAL) begin
                numeral <= '0;
                if (pass_q == LAST_PASS) begin
                    active <= 1'b0;
                    pass_q <= '0;
                end else begin
                    pass_q <= pass_q + 1'b1;
                end
            end else begin
                numeral <= numeral + 1'b1;
            end
        end
    end
endmodule

// File: rtl/display_mux.sv
// Chooses, per tube, between the live digit and the sweep numeral.
module display_mux
    import cycler_pkg::*;
(
    input  logic             override,
    input  logic [NIB-1:0]   numeral,
    input  logic [BCD_W-1:0] live_bcd,
    output logic [BCD_W-1:0] shown_bcd
);
    for (genvar t = 0; t < TUBES; t++) begin : g_tube
        // One selector per tube position.
        always_comb shown_bcd[t*NIB +: NIB] = override ? numeral : live_bcd[t*NIB +: NIB];
    end
endmodule

// File: rtl/cathode_exerciser.sv
// Top of the cathode exerciser. It passes the live time to the display
// and, on the hourly or 03:00 schedule, overrides all tubes with a
// repeated 0..9 walk. It never touches the time source.
// Assumes a synchronous active-low reset and a one-cycle tick.
module cathode_exerciser
    import cycler_pkg::*;
#(
    parameter int STEP_CYCLES = 1000000,
    parameter int PASSES      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BCD_W-1:0] live_bcd,
    input  logic             tick,
    input  logic             daily_sel,
    input  logic             enable,
    output logic [BCD_W-1:0] shown_bcd,
    output logic             busy
);
    logic           start;
    logic           step;
    logic           active;
    logic [NIB-1:0] numeral;

    sweep_trigger u_trig (
        .live_bcd (live_bcd),
        .tick     (tick),
        .enable   (enable),
        .daily_sel(daily_sel),
        .idle     (!active),
        .start    (start)
    );

    step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (active),
        .restart(start),
        .step   (step)
    );

    sweep_sequencer #(.PASSES(PASSES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .step   (step),
        .abort  (!enable),
        .active (active),
        .numeral(numeral)
    );

    // Enable gates the override so that an abort shows in the same cycle.
    always_comb busy = active && enable;

    display_mux u_mux (
        .override (busy),
        .numeral  (numeral),
        .live_bcd (live_bcd),
        .shown_bcd(shown_bcd)
    );
endmodule

// File: rtl/exerciser_checks.sv
// Property checker for cathode_exerciser, bound to every instance.
module exerciser_checks
    import cycler_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [BCD_W-1:0] live_bcd,
    input logic             tick,
    input logic             daily_sel,
    input logic             enable,
    input logic [BCD_W-1:0] shown_bcd,
    input logic             busy
);
    logic at_top;
    logic all_same;
    always_comb begin
        at_top   = (live_bcd[4*NIB-1:0] == '0);
        all_same = 1'b1;
        for (int t = 1; t < TUBES; t++)
            if (shown_bcd[t*NIB +: NIB] != shown_bcd[NIB-1:0]) all_same = 1'b0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy);

    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> shown_bcd == live_bcd);

    p_hourly_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && enable && !busy && at_top && !daily_sel) |=> (busy || !enable));

    p_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tick) |=> !busy);

    p_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> all_same);

    p_step_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && shown_bcd[NIB-1:0] != $past(shown_bcd[NIB-1:0])) |->
        ((shown_bcd[NIB-1:0] == $past(shown_bcd[NIB-1:0]) + 4'd1) ||
         ($past(shown_bcd[NIB-1:0]) == TOP_NUMERAL && shown_bcd[NIB-1:0] == '0)));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !busy);

    p_decimal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> shown_bcd[NIB-1:0] <= TOP_NUMERAL);
endmodule

bind cathode_exerciser exerciser_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_bcd (live_bcd),
    .tick     (tick),
    .daily_sel(daily_sel),
    .enable   (enable),
    .shown_bcd(shown_bcd),
    .busy     (busy)
);

// File: tb/test_cathode_exerciser.sv
// Directed bench for cathode_exerciser, one task per scenario.
module test_cathode_exerciser;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 3;
    localparam int NPASS      = 2;
    localparam int SWEEP_LEN  = 10 * STEP * NPASS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] live_bcd = '0;
    logic        tick = 1'b0;
    logic        daily_sel = 1'b0;
    logic        enable = 1'b1;
    logic [23:0] shown_bcd;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cathode_exerciser #(.STEP_CYCLES(STEP), .PASSES(NPASS)) i_cathode_exerciser (
        .clk(clk), .rst_n(rst_n), .live_bcd(live_bcd), .tick(tick),
        .daily_sel(daily_sel), .enable(enable), .shown_bcd(shown_bcd), .busy(busy)
    );

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [23:0] hms(input int h, input int m, input int s);
        return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10)};
    endfunction

    function automatic logic [23:0] fill(input int d);
        return {6{4'(d)}};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(busy == 1'b0, {req, " busy"}, 32'(busy), 32'd0);
        check(shown_bcd == live_bcd, {req, " shown"}, 32'(shown_bcd), 32'(live_bcd));
    endtask

    // Present a one-cycle tick; returns at the falling edge after the sampling edge.
    task automatic pulse_tick(input logic [23:0] t);
        @(negedge clk);
        live_bcd = t;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Walk a full sweep from the falling edge just after the start edge.
    task automatic run_sweep(input int inject_at, input int change_at, input logic [23:0] new_live);
        for (int c = 0; c < SWEEP_LEN; c++) begin
            check(busy == 1'b1, "R7 busy during sweep", 32'(busy), 32'd1);
            check(shown_bcd == fill((c / STEP) % 10), "R6 sweep numeral",
                  32'(shown_bcd), 32'(fill((c / STEP) % 10)));
            if (c == inject_at) begin
                live_bcd = hms(5, 0, 0);
                tick = 1'b1;
            end else begin
                tick = 1'b0;
            end
            if (c == change_at) live_bcd = new_live;
            @(negedge clk);
        end
        tick = 1'b0;
        check_idle("R7 R8 sweep end");
    endtask

    task automatic t_reset();
        live_bcd = hms(12, 34, 56);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
    endtask

    task automatic t_passthrough();
        live_bcd = hms(9, 59, 58); #1;
        check_idle("R2 pattern a");
        live_bcd = hms(21, 7, 3); #1;
        check_idle("R2 pattern b");
    endtask

    task automatic t_hourly();
        daily_sel = 1'b0;
        pulse_tick(hms(14, 0, 0));
        check(busy == 1'b1, "R3 hourly start", 32'(busy), 32'd1);
        run_sweep(-1, SWEEP_LEN / 2, hms(14, 0, 30));
        check(shown_bcd == hms(14, 0, 30), "R8 live after sweep", 32'(shown_bcd), 32'(hms(14, 0, 30)));
    endtask

    task automatic t_daily_hit();
        daily_sel = 1'b1;
        pulse_tick(hms(3, 0, 0));
        check(busy == 1'b1, "R4 daily at 03", 32'(busy), 32'd1);
        run_sweep(-1, -1, '0);
        daily_sel = 1'b0;
    endtask

    task automatic t_daily_miss();
        daily_sel = 1'b1;
        pulse_tick(hms(4, 0, 0));
        check_idle("R4 daily not at 04");
        pulse_tick(hms(13, 0, 0));
        check_idle("R4 daily not at 13");
        daily_sel = 1'b0;
    endtask

    task automatic t_no_trigger();
        pulse_tick(hms(14, 0, 1));
        check_idle("R5 seconds nonzero");
        pulse_tick(hms(14, 10, 0));
        check_idle("R5 minutes nonzero");
        enable = 1'b0;
        pulse_tick(hms(14, 0, 0));
        check_idle("R5 enable low");
        enable = 1'b1;
        @(negedge clk);
        live_bcd = hms(15, 0, 0);
        repeat (4) @(negedge clk);
        check_idle("R5 no tick");
    endtask

    task automatic t_abort();
        pulse_tick(hms(16, 0, 0));
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R9 running before abort", 32'(busy), 32'd1);
        live_bcd = hms(16, 0, 6);
        enable = 1'b0; #1;
        check_idle("R9 abort same cycle");
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R9 no resume");
    endtask

    task automatic t_tick_ignored();
        pulse_tick(hms(17, 0, 0));
        run_sweep(STEP * 4 + 1, -1, '0);
        check(busy == 1'b0, "R10 not extended", 32'(busy), 32'd0);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_hourly();
        t_daily_hit();
        t_daily_miss();
        t_no_trigger();
        t_abort();
        t_tick_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule